// File: doc/BRIEF.md
# Masked Chi Row (Domain-Oriented, Any Order)

This block evaluates the nonlinear chi step of the Keccak permutation on a single 5-bit row of the state. The row arrives already split into ORDER+1 Boolean shares. XORing all shares gives the true row, and no single share reveals anything about it. The masking order ORDER is a compile-time parameter. Every one of the five AND gates inside chi is built in the domain-oriented style. A product of two shares from the same domain stays in that domain. A product that crosses two domains is blinded with a fresh random bit and captured in its own flip-flop before any XOR folds it into an output share. The result is a shared 5-bit row, valid one clock after the input.

The surrounding datapath presents a shared row, a fresh random word and a valid strobe in the same cycle. It collects the shared result and a matching valid strobe on the next cycle. There is no stall path: a new row can be accepted every cycle. The random word holds 5·ORDER·(ORDER+1)/2 bits and must be refreshed for every evaluation.

Top module: `masked_chi_row`

## Requirements
- R1: `out_valid` is high in a cycle exactly when `in_valid` was high in the cycle before. Rows are accepted back-to-back with no stall, and every accepted row produces exactly one result.
- R2: Share s of a row occupies bits [5s+4:5s], and bit k of a share is row bit k. For a row accepted with `in_valid`, the XOR of all result shares on the next cycle equals chi(a), where a is the XOR of all input shares and chi(a)[k] = a[k] XOR (NOT a[(k+1) mod 5] AND a[(k+2) mod 5]).
- R3: The recombined result depends only on the unshared row. Any split of that row into shares, and any value of the random word, gives the same recombined result.
- R4: `rnd` is 5·ORDER·(ORDER+1)/2 bits wide. Let P = ORDER·(ORDER+1)/2. Bit g·P+p serves AND gate g (the gate that forms result bit g) for share pair number p. Pairs (i,j) with i<j are numbered in the order (0,1),(0,2)…(0,ORDER),(1,2),(1,3)… Flipping that one random bit, with all else held, flips exactly bit g of result share i and bit g of result share j.
- R5: While `rst_n` is low, `out_valid` is 0 and `res_sh` is all zeros.
- R6: If every input share except share 0 is zero and `rnd` is zero, result share 0 equals chi of share 0 and every other result share is zero.
- R7: Outputs change only at rising clock edges. A change of `row_sh`, `rnd` or `in_valid` between edges does not reach `res_sh` or `out_valid` before the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Shared row and random word are valid this cycle |
| row_sh | input | 5·(ORDER+1) | Shared input row, share s at bits [5s+4:5s] |
| rnd | input | 5·ORDER·(ORDER+1)/2 | Fresh random bits for this evaluation |
| out_valid | output | 1 | Result shares are valid this cycle |
| res_sh | output | 5·(ORDER+1) | Shared result row, same layout as `row_sh` |

## Verification
The bench targets the cases where the blinding bits must cancel. A gate that adds a random bit to only one half of a cross pair gives a recombined row that varies with `rnd`. Reusing or misplacing a random bit moves the flipped output bits off the expected pair of shares, and inverting the wrong share or more than one share breaks chi. The bench also checks a degenerate split with all upper shares zero, back-to-back rows with gaps, and mid-cycle input changes; a design with a combinational bypass around the register would let those changes reach the outputs early. All three orders 1, 2 and 3 are run against an unmasked reference.

// File: rtl/masked_chi_pkg.sv
package masked_chi_pkg;

  localparam int ROW_W = 5;

  // Number of unordered share pairs for a given share count.
  function automatic int pair_count(input int shares);
    return shares * (shares - 1) / 2;
  endfunction

  // Position of pair (lo,hi), lo<hi, in the order (0,1),(0,2)..,(1,2),..
  function automatic int pair_index(input int lo, input int hi, input int shares);
    return lo * shares - (lo * (lo + 1)) / 2 + (hi - lo - 1);
  endfunction

  // Wrap a row bit index into 0..ROW_W-1.
  function automatic int wrap_bit(input int k);
    return k % ROW_W;
  endfunction

  // Unshared chi on one row.
  function automatic logic [ROW_W-1:0] chi_row(input logic [ROW_W-1:0] a);
    logic [ROW_W-1:0] r;
    for (int k = 0; k < ROW_W; k++) begin
      r[k] = a[k] ^ (~a[wrap_bit(k + 1)] & a[wrap_bit(k + 2)]);
    end
    return r;
  endfunction

endpackage

// File: rtl/mchi_row_route.sv
module mchi_row_route
  import masked_chi_pkg::*;
#(
  parameter int SHARES = 2,
  parameter int NPAIR  = SHARES * (SHARES - 1) / 2
) (
  input  logic [SHARES*ROW_W-1:0]           row_sh,
  input  logic [ROW_W*NPAIR-1:0]            rnd,
  output logic [ROW_W-1:0][SHARES-1:0]      lin_sh,
  output logic [ROW_W-1:0][SHARES-1:0]      neg_sh,
  output logic [ROW_W-1:0][SHARES-1:0]      con_sh,
  output logic [ROW_W-1:0][NPAIR-1:0]       z_bits
);

  // For gate g: linear term is bit g, the inverted AND operand is bit g+1,
  // the plain AND operand is bit g+2. Only share 0 carries the inversion.
  always_comb begin
    for (int g = 0; g < ROW_W; g++) begin
      for (int s = 0; s < SHARES; s++) begin
        lin_sh[g][s] = row_sh[s*ROW_W + g];
        neg_sh[g][s] = row_sh[s*ROW_W + wrap_bit(g + 1)] ^ (s == 0);
        con_sh[g][s] = row_sh[s*ROW_W + wrap_bit(g + 2)];
      end
      z_bits[g] = rnd[g*NPAIR +: NPAIR];
    end
  end

endmodule

// File: rtl/mchi_dom_gate.sv
module mchi_dom_gate
  import masked_chi_pkg::*;
#(
  parameter int SHARES = 2,
  parameter int NPAIR  = SHARES * (SHARES - 1) / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SHARES-1:0] lin_sh,
  input  logic [SHARES-1:0] neg_sh,
  input  logic [SHARES-1:0] con_sh,
  input  logic [NPAIR-1:0]  z,
  output logic [SHARES-1:0] r_sh
);

  // term_d[s][t]: contribution to output domain s built from share s of the
  // inverted operand and share t of the plain operand. The diagonal carries
  // the inner-domain product plus the linear term; off-diagonal entries are
  // cross-domain products blinded by the pair's random bit.
  logic [SHARES-1:0][SHARES-1:0] term_d;
  logic [SHARES-1:0][SHARES-1:0] term_q;

  always_comb begin
    for (int s = 0; s < SHARES; s++) begin
      for (int t = 0; t < SHARES; t++) begin
        if (s == t) begin
          term_d[s][t] = lin_sh[s] ^ (neg_sh[s] & con_sh[s]);
        end else if (s < t) begin
          term_d[s][t] = (neg_sh[s] & con_sh[t]) ^ z[pair_index(s, t, SHARES)];
        end else begin
          term_d[s][t] = (neg_sh[s] & con_sh[t]) ^ z[pair_index(t, s, SHARES)];
        end
      end
    end
  end

  // Every term gets its own flop: nothing mixes domains before this stage.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      term_q <= '0;
    end else begin
      term_q <= term_d;
    end
  end

  // Fold the registered terms of each domain into its output share.
  always_comb begin
    for (int s = 0; s < SHARES; s++) begin
      r_sh[s] = 1'b0;
      for (int t = 0; t < SHARES; t++) begin
        r_sh[s] = r_sh[s] ^ term_q[s][t];
      end
    end
  end

endmodule

// File: rtl/mchi_valid_stage.sv
module mchi_valid_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic vld_in,
  output logic vld_out
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_out <= 1'b0;
    end else begin
      vld_out <= vld_in;
    end
  end

endmodule

// File: rtl/masked_chi_row.sv
module masked_chi_row
  import masked_chi_pkg::*;
#(
  parameter int ORDER = 1
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     in_valid,
  input  logic [(ORDER+1)*5-1:0]                   row_sh,
  input  logic [5*(ORDER*(ORDER+1)/2)-1:0]         rnd,
  output logic                                     out_valid,
  output logic [(ORDER+1)*5-1:0]                   res_sh
);

  localparam int SHARES = ORDER + 1;
  localparam int NPAIR  = pair_count(SHARES);

  logic [ROW_W-1:0][SHARES-1:0] lin_w;
  logic [ROW_W-1:0][SHARES-1:0] neg_w;
  logic [ROW_W-1:0][SHARES-1:0] con_w;
  logic [ROW_W-1:0][NPAIR-1:0]  z_w;
  logic [ROW_W-1:0][SHARES-1:0] gate_out;

  mchi_row_route #(
    .SHARES (SHARES),
    .NPAIR  (NPAIR)
  ) route_i (
    .row_sh (row_sh),
    .rnd    (rnd),
    .lin_sh (lin_w),
    .neg_sh (neg_w),
    .con_sh (con_w),
    .z_bits (z_w)
  );

  for (genvar g = 0; g < ROW_W; g++) begin : g_gate
    mchi_dom_gate #(
      .SHARES (SHARES),
      .NPAIR  (NPAIR)
    ) gate_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .lin_sh (lin_w[g]),
      .neg_sh (neg_w[g]),
      .con_sh (con_w[g]),
      .z      (z_w[g]),
      .r_sh   (gate_out[g])
    );
  end

  mchi_valid_stage vld_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .vld_in  (in_valid),
    .vld_out (out_valid)
  );

  // Regroup gate-major outputs into the share-major result bus.
  always_comb begin
    for (int s = 0; s < SHARES; s++) begin
      for (int g = 0; g < ROW_W; g++) begin
        res_sh[s*ROW_W + g] = gate_out[g][s];
      end
    end
  end

endmodule

// File: rtl/masked_chi_row_chk.sv
module masked_chi_row_chk
  import masked_chi_pkg::*;
#(
  parameter int ORDER = 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic [(ORDER+1)*5-1:0] row_sh,
  input logic                   out_valid,
  input logic [(ORDER+1)*5-1:0] res_sh
);

  localparam int SHARES = ORDER + 1;

  logic [ROW_W-1:0] in_fold;
  logic [ROW_W-1:0] out_fold;

  always_comb begin
    in_fold  = '0;
    out_fold = '0;
    for (int s = 0; s < SHARES; s++) begin
      in_fold  = in_fold ^ row_sh[s*ROW_W +: ROW_W];
      out_fold = out_fold ^ res_sh[s*ROW_W +: ROW_W];
    end
  end

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_valid_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_recombine_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_fold == chi_row($past(in_fold))));

  assert_result_known_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !$isunknown(res_sh));

endmodule

bind masked_chi_row masked_chi_row_chk #(.ORDER(ORDER)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .row_sh    (row_sh),
  .out_valid (out_valid),
  .res_sh    (res_sh)
);

// File: tb/masked_chi_row_tb_top.sv
module masked_chi_row_tb_lane #(
  parameter int ORDER = 1
) (
  input logic clk,
  input logic rst_n
);

  localparam int SH = ORDER + 1;
  localparam int NP = ORDER * (ORDER + 1) / 2;
  localparam int RW = 5 * NP;
  localparam int BW = 5 * SH;

  logic          in_valid = 1'b0;
  logic [BW-1:0] row_sh   = '0;
  logic [RW-1:0] rnd      = '0;
  logic          out_valid;
  logic [BW-1:0] res_sh;

  masked_chi_row #(.ORDER(ORDER)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .row_sh    (row_sh),
    .rnd       (rnd),
    .out_valid (out_valid),
    .res_sh    (res_sh)
  );

  int       n_tests = 0;
  int       n_fail  = 0;
  bit       done    = 1'b0;
  logic [4:0] exp_q[$];
  string      tag_q[$];

  // Reference chi written with rotations instead of per-bit indexing.
  function automatic logic [4:0] ref_chi(input logic [4:0] a);
    logic [4:0] r1, r2;
    r1 = {a[0], a[4:1]};
    r2 = {a[1:0], a[4:2]};
    return a ^ (~r1 & r2);
  endfunction

  function automatic logic [4:0] fold(input logic [BW-1:0] v);
    logic [4:0] acc = '0;
    for (int s = 0; s < SH; s++) acc ^= v[s*5 +: 5];
    return acc;
  endfunction

  function automatic logic [BW-1:0] split(input logic [4:0] row);
    logic [BW-1:0] v = '0;
    logic [4:0] acc = row;
    for (int s = 1; s < SH; s++) begin
      logic [4:0] part = 5'($urandom);
      v[s*5 +: 5] = part;
      acc ^= part;
    end
    v[4:0] = acc;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL order=%0d %s %s actual=%h expected=%h", ORDER, req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [4:0] row, input logic [BW-1:0] sh,
                       input logic [RW-1:0] r, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    row_sh   = sh;
    rnd      = r;
    exp_q.push_back(ref_chi(row));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
      row_sh   = BW'($urandom);
      rnd      = RW'($urandom);
    end
  endtask

  // Monitor: out_valid must echo in_valid of the previous edge; results pop
  // the scoreboard in order.
  initial begin
    logic pv;
    forever begin
      @(posedge clk);
      pv = in_valid;
      #2;
      if (rst_n) begin
        check(out_valid == pv, "R1", "out_valid vs prior in_valid", out_valid, pv);
        if (out_valid) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R1", "result with nothing pending", 1, 0);
          end else begin
            logic [4:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(fold(res_sh) == e, t, "recombined row", fold(res_sh), e);
          end
        end
      end
    end
  end

  initial begin
    logic [BW-1:0] r1, r2, sh;
    logic [RW-1:0] rr;
    logic [4:0]    row;
    // R5: hold junk on inputs during reset
    @(negedge clk);
    in_valid = 1'b1;
    row_sh   = BW'($urandom);
    rnd      = RW'($urandom);
    @(negedge clk);
    check(out_valid == 1'b0 && res_sh == '0, "R5", "outputs in reset",
          {out_valid, res_sh}, 0);
    in_valid = 1'b0;
    wait (rst_n == 1'b1);

    // R2: every row value, back to back, random splits and masks
    for (int v = 0; v < 32; v++) apply(5'(v), split(5'(v)), RW'($urandom), "R2");

    // R3: one row, many splits and masks, with and without gaps
    row = 5'h16;
    for (int i = 0; i < 8; i++) begin
      apply(row, split(row), RW'($urandom), "R3");
      if (i % 2 == 1) idle(1);
    end

    // R6: trivial split and zero randomness
    idle(1);
    row = 5'h13;
    sh  = '0;
    sh[4:0] = row;
    apply(row, sh, '0, "R2");
    @(posedge clk); #3;
    begin
      logic [BW-1:0] want = '0;
      want[4:0] = ref_chi(row);
      check(res_sh == want, "R6", "degenerate split shares", res_sh, want);
    end
    idle(1);

    // R4: each random bit lands on exactly its gate's pair of shares
    for (int k = 0; k < RW; k++) begin
      int g, p, cnt, pi, pj;
      logic [BW-1:0] mask;
      g = k / NP;
      p = k % NP;
      cnt = 0; pi = 0; pj = 1;
      for (int i = 0; i < SH; i++)
        for (int j = i + 1; j < SH; j++) begin
          if (cnt == p) begin pi = i; pj = j; end
          cnt++;
        end
      mask = '0;
      mask[pi*5 + g] = 1'b1;
      mask[pj*5 + g] = 1'b1;
      row = 5'($urandom);
      sh  = split(row);
      rr  = RW'($urandom);
      apply(row, sh, rr, "R4");
      @(posedge clk); #3;
      r1 = res_sh;
      apply(row, sh, rr ^ (RW'(1) << k), "R4");
      @(posedge clk); #3;
      r2 = res_sh;
      check((r1 ^ r2) == mask, "R4", "share bits flipped by one random bit",
            r1 ^ r2, mask);
    end

    // R7: mid-cycle input changes do not reach the outputs
    idle(2);
    @(posedge clk); #3;
    r1 = res_sh;
    row = 5'($urandom);
    apply(row, split(row), RW'($urandom), "R2");
    #2;
    check(res_sh == r1 && out_valid == 1'b0, "R7", "outputs before edge",
          {out_valid, res_sh}, {1'b0, r1});

    // R2/R3: random traffic with random gaps
    for (int n = 0; n < 300; n++) begin
      if ($urandom % 3 == 0) idle(1);
      row = 5'($urandom);
      apply(row, split(row), RW'($urandom), "R2");
    end

    idle(4);
    check(exp_q.size() == 0, "R1", "rows left without result", exp_q.size(), 0);
    done = 1'b1;
  end

endmodule

module masked_chi_row_tb_top;

  localparam int CLK_PERIOD = 10;

  logic clk   = 1'b0;
  logic rst_n = 1'b0;
  bit   wd_hit = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  masked_chi_row_tb_lane #(.ORDER(1)) lane1 (.clk(clk), .rst_n(rst_n));
  masked_chi_row_tb_lane #(.ORDER(2)) lane2 (.clk(clk), .rst_n(rst_n));
  masked_chi_row_tb_lane #(.ORDER(3)) lane3 (.clk(clk), .rst_n(rst_n));

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    wd_hit = 1'b1;
  end

  initial begin
    int tests, fails;
    wait ((lane1.done && lane2.done && lane3.done) || wd_hit);
    tests = lane1.n_tests + lane2.n_tests + lane3.n_tests;
    fails = lane1.n_fail + lane2.n_fail + lane3.n_fail;
    if (wd_hit) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule